// File: doc/BRIEF.md
# Compare-Output Timer with PWM

This block is a general-purpose up-counter with two compare registers and two registered output pins. Every clock the counter either steps by one, returns to zero, or takes a value written over the register bus. Whenever the count equals a compare register, the pin tied to that register can be left alone, driven low, driven high or flipped. Output A follows compare register 0 and output B follows compare register 1. A control register selects between a free-running count and an interval count whose period is set by compare register 1.

Setting the waveform bit of the control register turns output A into a pulse-width generator. Compare register 1 then sets the period and compare register 0 sets the point where the pulse ends. The two action fields stop meaning pin actions and instead select the pulse polarity. Ten low control bits are plain storage for input-capture settings. They are read back but drive no logic. Software reaches the four registers through a single-cycle synchronous write port and a combinational read port.

Top module: `cmp_pwm_timer`

## Requirements
- R1: After reset the control, compare 0, compare 1 and count registers all read 0, and both output pins are low.
- R2: Control bits 31:16 always read 0, and a write of ones to those bits leaves the control value at 0.
- R3: Control bits 9:0 store whatever is written and read it back unchanged. They have no effect on the pins or on the count.
- R4: When no clear and no bus load applies, the count rises by exactly one per clock and wraps from its maximum to 0.
- R5: When control bit 14 is 1, a count equal to compare register 1 is followed on the next clock by a count of 0.
- R6: Outside waveform mode, a cycle where the count equals compare register 1 applies the action in control bits 13:12 to output B, visible from the next cycle. The codes are 00 keep, 01 low, 10 high and 11 flip. In every other cycle output B keeps its level.
- R7: Outside waveform mode, a cycle where the count equals compare register 0 applies the action in control bits 11:10 to output A, using the same four codes as R6. Output A is unaffected by compare register 1.
- R8: When control bit 15 is 1, the count clears after it equals compare register 1, whatever bit 14 holds. If compare 0 is below compare 1, output A is active while the count lies in 0 to compare 0, and inactive for the rest of each period. Code 01 in both action fields makes the active level high, and code 10 in both makes it low.
- R9: In waveform mode, output A stays low if either action field holds 00 or 11, or if the two fields differ. Output B keeps its level for as long as waveform mode is on.
- R10: Register word addresses are 0 for control, 1 for compare 0, 2 for compare 1 and 3 for the count. A write to address 3 loads the count on that clock and takes priority over the step and the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, zero-extended |
| out_a | output | 1 | Compare-0 output, or the pulse-width waveform |
| out_b | output | 1 | Compare-1 output |

## Verification
The bench builds the block with an 8-bit count, a 32-bit data bus and a 2-bit address. The narrow count brings the wrap from 255 to 0 within a handful of clocks after a load. It also keeps every compare match in the tests only a few cycles after the count is placed just below it. The 32-bit bus lets the bench write ones into the reserved control bits and confirm they read back as zero.

// File: rtl/cpt_pkg.sv
`timescale 1ns/1ps
package cpt_pkg;

   localparam int CTRL_W  = 16;
   localparam int F_WAVE  = 15;
   localparam int F_IVL   = 14;
   localparam int F_BACT  = 12;
   localparam int F_AACT  = 10;

   localparam int NREG      = 4;
   localparam int REG_CTRL  = 0;
   localparam int REG_CMP0  = 1;
   localparam int REG_CMP1  = 2;
   localparam int REG_COUNT = 3;

   typedef enum logic [1:0] {
      ACT_KEEP = 2'b00,
      ACT_LOW  = 2'b01,
      ACT_HIGH = 2'b10,
      ACT_FLIP = 2'b11
   } act_e;

   localparam logic [1:0] POL_ACT_HI = 2'b01;
   localparam logic [1:0] POL_ACT_LO = 2'b10;

   function automatic logic act_next(input logic cur, input act_e a);
      case (a)
         ACT_LOW:  return 1'b0;
         ACT_HIGH: return 1'b1;
         ACT_FLIP: return ~cur;
         default:  return cur;
      endcase
   endfunction

   function automatic logic pol_ok(input logic [1:0] a, input logic [1:0] b);
      return (a == b) && ((a == POL_ACT_HI) || (a == POL_ACT_LO));
   endfunction

endpackage

// File: rtl/cpt_counter.sv
`timescale 1ns/1ps
module cpt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             ivl_en,
   input  logic             top_hit,
   output logic [CNT_W-1:0] count
);

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("cpt_counter: CNT_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (ld) begin
         count <= ld_val;
      end else if (ivl_en && top_hit) begin
         count <= '0;
      end else begin
         count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/cpt_regs.sv
`timescale 1ns/1ps
module cpt_regs
   import cpt_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [CNT_W-1:0]    count,
   output logic [CTRL_W-1:F_AACT] ctrl_mode,
   output logic [CNT_W-1:0]    cmp0,
   output logic [CNT_W-1:0]    cmp1,
   output logic                cnt_ld,
   output logic [CNT_W-1:0]    cnt_ld_val
);

   logic [CTRL_W-1:0] ctrl_q;
   logic [NREG-1:0]   hit;
   logic              unused_wdata;

   generate
      if (ADDR_W < 2) begin : g_bad_a
         $error("cpt_regs: ADDR_W must reach four registers");
      end
      if (DATA_W < CTRL_W) begin : g_bad_d
         $error("cpt_regs: DATA_W narrower than the control register");
      end
      if (CNT_W > DATA_W) begin : g_bad_c
         $error("cpt_regs: CNT_W wider than DATA_W");
      end
      for (genvar i = 0; i < NREG; i++) begin : g_hit
         assign hit[i] = bus_wr && (bus_addr == ADDR_W'(i));
      end
   endgenerate

   assign unused_wdata = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         cmp0   <= '0;
         cmp1   <= '0;
      end else begin
         if (hit[REG_CTRL]) ctrl_q <= bus_wdata[CTRL_W-1:0];
         if (hit[REG_CMP0]) cmp0   <= bus_wdata[CNT_W-1:0];
         if (hit[REG_CMP1]) cmp1   <= bus_wdata[CNT_W-1:0];
      end
   end

   assign cnt_ld     = hit[REG_COUNT];
   assign cnt_ld_val = bus_wdata[CNT_W-1:0];
   assign ctrl_mode  = ctrl_q[CTRL_W-1:F_AACT];

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(REG_CTRL):  bus_rdata[CTRL_W-1:0] = ctrl_q;
         ADDR_W'(REG_CMP0):  bus_rdata[CNT_W-1:0]  = cmp0;
         ADDR_W'(REG_CMP1):  bus_rdata[CNT_W-1:0]  = cmp1;
         ADDR_W'(REG_COUNT): bus_rdata[CNT_W-1:0]  = count;
         default:            bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/cpt_pin.sv
`timescale 1ns/1ps
module cpt_pin
   import cpt_pkg::*;
#(
   parameter bit HAS_WAVE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  act_e code,
   input  logic wave_on,
   input  logic wave_ok,
   input  logic wave_low,
   input  logic start_hit,
   output logic pin
);

   generate
      if (HAS_WAVE) begin : g_wave
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pin <= 1'b0;
            end else if (wave_on) begin
               if (!wave_ok)       pin <= 1'b0;
               else if (hit)       pin <= wave_low;
               else if (start_hit) pin <= ~wave_low;
            end else if (hit) begin
               pin <= act_next(pin, code);
            end
         end
      end else begin : g_plain
         logic unused_wave;
         assign unused_wave = ^{wave_ok, wave_low, start_hit};
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pin <= 1'b0;
            end else if (!wave_on && hit) begin
               pin <= act_next(pin, code);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/cmp_pwm_timer.sv
`timescale 1ns/1ps
module cmp_pwm_timer
   import cpt_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              out_a,
   output logic              out_b
);

   logic [CTRL_W-1:F_AACT] ctrl_mode;
   logic [CNT_W-1:0]       cmp0_q;
   logic [CNT_W-1:0]       cmp1_q;
   logic [CNT_W-1:0]       count_q;
   logic [CNT_W-1:0]       ld_val;
   logic                   ld;
   logic                   hit0;
   logic                   hit1;
   logic                   wave_on;
   logic                   ivl_on;
   logic                   wave_ok;
   logic                   wave_low;
   logic [1:0]             fld_a;
   logic [1:0]             fld_b;

   cpt_regs #(
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .count      (count_q),
      .ctrl_mode  (ctrl_mode),
      .cmp0       (cmp0_q),
      .cmp1       (cmp1_q),
      .cnt_ld     (ld),
      .cnt_ld_val (ld_val)
   );

   assign fld_a    = ctrl_mode[F_AACT+1:F_AACT];
   assign fld_b    = ctrl_mode[F_BACT+1:F_BACT];
   assign wave_on  = ctrl_mode[F_WAVE];
   assign ivl_on   = ctrl_mode[F_IVL] | wave_on;
   assign wave_ok  = pol_ok(fld_a, fld_b);
   assign wave_low = (fld_a == POL_ACT_LO);
   assign hit0     = (count_q == cmp0_q);
   assign hit1     = (count_q == cmp1_q);

   cpt_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (ld),
      .ld_val  (ld_val),
      .ivl_en  (ivl_on),
      .top_hit (hit1),
      .count   (count_q)
   );

   cpt_pin #(
      .HAS_WAVE (1'b1)
   ) u_pin_a (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit0),
      .code      (act_e'(fld_a)),
      .wave_on   (wave_on),
      .wave_ok   (wave_ok),
      .wave_low  (wave_low),
      .start_hit (hit1),
      .pin       (out_a)
   );

   cpt_pin #(
      .HAS_WAVE (1'b0)
   ) u_pin_b (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit1),
      .code      (act_e'(fld_b)),
      .wave_on   (wave_on),
      .wave_ok   (wave_ok),
      .wave_low  (wave_low),
      .start_hit (hit0),
      .pin       (out_b)
   );

endmodule

// File: rtl/cpt_chk.sv
`timescale 1ns/1ps
module cpt_chk #(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [CNT_W-1:0]  ld_val,
   input logic [CNT_W-1:0]  count,
   input logic [CNT_W-1:0]  cmp0,
   input logic [CNT_W-1:0]  cmp1,
   input logic [5:0]        mode,
   input logic              out_a,
   input logic              out_b
);

   logic ld;
   assign ld = bus_wr && (bus_addr == ADDR_W'(3));

   // R10
   cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> count == $past(ld_val));

   // R4
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !((mode[4] || mode[5]) && count == cmp1))
      |=> count == CNT_W'($past(count) + 1'b1));

   // R5
   ivl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && mode[4] && count == cmp1) |=> count == '0);

   // R6
   b_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count != cmp1 || mode[5]) |=> $stable(out_b));

   // R6
   b_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode[5] && count == cmp1 && mode[3:2] == 2'b10) |=> out_b);

   // R7
   a_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode[5] && count == cmp0 && mode[1:0] == 2'b11)
      |=> out_a != $past(out_a));

   // R7
   a_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode[5] && count != cmp0) |=> $stable(out_a));

   // R8
   wave_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[5] && mode[3:0] == 4'b0101 && count == cmp0) |=> !out_a);

   // R9
   wave_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[5] && (mode[3:2] != mode[1:0] || mode[1:0] == 2'b00
                   || mode[1:0] == 2'b11)) |=> !out_a);

endmodule

bind cmp_pwm_timer cpt_chk #(
   .CNT_W  (CNT_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .ld_val   (bus_wdata[CNT_W-1:0]),
   .count    (count_q),
   .cmp0     (cmp0_q),
   .cmp1     (cmp1_q),
   .mode     (ctrl_mode),
   .out_a    (out_a),
   .out_b    (out_b)
);

// File: tb/tb_cmp_pwm_timer.sv
`timescale 1ns/1ps
module tb_cmp_pwm_timer;

   localparam int CNT_W  = 8;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 2;

   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_CMP0 = 2'd1;
   localparam logic [1:0] A_CMP1 = 2'd2;
   localparam logic [1:0] A_CNT  = 2'd3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic              out_a;
   logic              out_b;

   always #2.5 clk = ~clk;

   cmp_pwm_timer #(
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .out_a     (out_a),
      .out_b     (out_b)
   );

   typedef struct {
      string       tag;
      logic [31:0] exp;
      logic [31:0] act;
   } item_t;

   item_t sbq[$];
   event  chk_ev;
   int    n_run  = 0;
   int    n_fail = 0;
   bit    done   = 1'b0;

   task automatic drain();
      while (sbq.size() > 0) begin
         item_t it;
         it = sbq.pop_front();
         n_run++;
         if (it.act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", it.tag, it.act, it.exp);
         end
      end
   endtask

   initial begin
      forever begin
         @(chk_ev);
         drain();
      end
   end

   task automatic expect_eq(input string tag, input logic [31:0] act,
                            input logic [31:0] exp);
      sbq.push_back('{tag: tag, exp: exp, act: act});
      -> chk_ev;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr    = 1'b1;
      bus_addr  = a;
      bus_wdata = d;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic duty(output int hi);
      hi = 0;
      repeat (10) begin
         @(negedge clk);
         #0.5;
         if (out_a) hi++;
      end
   endtask

   logic b_model;
   logic a_model;

   task automatic b_case(input logic [1:0] code, input string tag);
      wr(A_CNT, 32'd100);
      wr(A_CTRL, {18'd0, code, 12'd0});
      wr(A_CNT, 32'd15);
      #0.5;
      expect_eq({tag, " before match"}, {31'd0, out_b}, {31'd0, b_model});
      case (code)
         2'b01: b_model = 1'b0;
         2'b10: b_model = 1'b1;
         2'b11: b_model = ~b_model;
         default: b_model = b_model;
      endcase
      step(10);
      #0.5;
      expect_eq({tag, " after match"}, {31'd0, out_b}, {31'd0, b_model});
   endtask

   task automatic a_case(input logic [1:0] code, input string tag);
      wr(A_CNT, 32'd100);
      wr(A_CTRL, {20'd0, code, 10'd0});
      wr(A_CNT, 32'd35);
      #0.5;
      expect_eq({tag, " before match"}, {31'd0, out_a}, {31'd0, a_model});
      case (code)
         2'b01: a_model = 1'b0;
         2'b10: a_model = 1'b1;
         2'b11: a_model = ~a_model;
         default: a_model = a_model;
      endcase
      step(10);
      #0.5;
      expect_eq({tag, " after match"}, {31'd0, out_a}, {31'd0, a_model});
   endtask

   task automatic wave_case(input logic [31:0] ctrl, input int exp_hi,
                            input string tag);
      int hi;
      wr(A_CTRL, ctrl);
      wr(A_CNT, 32'd0);
      step(12);
      duty(hi);
      expect_eq(tag, 32'(hi), 32'(exp_hi));
   endtask

   initial begin
      logic [31:0] v;
      b_model = 1'b0;
      a_model = 1'b0;
      step(3);
      rst_n = 1'b1;
      #0.5;
      // R1 reset state
      expect_eq("R1 out_a", {31'd0, out_a}, 32'd0);
      expect_eq("R1 out_b", {31'd0, out_b}, 32'd0);
      rd(A_CNT, v);  expect_eq("R1 count", v, 32'd0);
      rd(A_CTRL, v); expect_eq("R1 ctrl", v, 32'd0);
      rd(A_CMP0, v); expect_eq("R1 cmp0", v, 32'd0);
      rd(A_CMP1, v); expect_eq("R1 cmp1", v, 32'd0);

      // R2 reserved bits
      wr(A_CTRL, 32'hFFFF_0000);
      rd(A_CTRL, v); expect_eq("R2 reserved read", v, 32'd0);

      // R3 capture field storage, no side effect
      wr(A_CTRL, 32'h0000_03FF);
      rd(A_CTRL, v); expect_eq("R3 capture readback", v, 32'h3FF);
      wr(A_CNT, 32'd5);
      step(3);
      rd(A_CNT, v); expect_eq("R3 count unaffected", v, 32'd8);
      expect_eq("R3 pins unaffected", {30'd0, out_a, out_b}, 32'd0);

      // R10 compare registers through the bus
      wr(A_CMP1, 32'd20);
      wr(A_CMP0, 32'd40);
      rd(A_CMP1, v); expect_eq("R10 cmp1 readback", v, 32'd20);
      rd(A_CMP0, v); expect_eq("R10 cmp0 readback", v, 32'd40);

      // R6 output B action codes
      b_case(2'b10, "R6 code10");
      b_case(2'b01, "R6 code01");
      b_case(2'b11, "R6 code11");
      b_case(2'b00, "R6 code00");
      b_case(2'b11, "R6 code11b");
      b_case(2'b10, "R6 code10b");

      // R7 output A action codes
      a_case(2'b10, "R7 code10");
      a_case(2'b01, "R7 code01");
      a_case(2'b11, "R7 code11");
      a_case(2'b00, "R7 code00");
      a_case(2'b11, "R7 code11b");

      // R4 free-running wrap
      wr(A_CTRL, 32'd0);
      wr(A_CNT, 32'd250);
      step(10);
      rd(A_CNT, v); expect_eq("R4 wrap", v, 32'd4);

      // R5 interval clear
      wr(A_CMP1, 32'd9);
      wr(A_CTRL, 32'h0000_4000);
      wr(A_CNT, 32'd0);
      step(15);
      rd(A_CNT, v); expect_eq("R5 mid period", v, 32'd5);
      step(4);
      rd(A_CNT, v); expect_eq("R5 at top", v, 32'd9);
      step(1);
      rd(A_CNT, v); expect_eq("R5 cleared", v, 32'd0);

      // R8 waveform mode, counter clears without bit 14
      wr(A_CMP0, 32'd3);
      wr(A_CTRL, 32'h0000_9400);
      wr(A_CNT, 32'd0);
      step(12);
      rd(A_CNT, v); expect_eq("R8 wave period clear", v, 32'd2);
      wave_case(32'h0000_9400, 4, "R8 active high duty");
      wave_case(32'h0000_A800, 6, "R8 active low duty");

      // R9 invalid polarity codes, B frozen
      wave_case(32'h0000_8000, 0, "R9 code00 no pulse");
      wave_case(32'h0000_BC00, 0, "R9 code11 no pulse");
      wave_case(32'h0000_9800, 0, "R9 mismatch no pulse");
      #0.5;
      expect_eq("R9 out_b held", {31'd0, out_b}, {31'd0, b_model});

      drain();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #500000;
      if (!done) begin
         done = 1'b1;
         drain();
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule